// File: doc/BRIEF.md
# Block-Linear GOB Address Generator

This block turns a byte coordinate on a surface (a byte column `x` and a line `y`) into the byte offset that the coordinate has in a block-linear memory layout. The layout's basic unit is a group of bytes (GOB) that is 64 bytes wide and 8 lines tall and fills 512 consecutive bytes. Inside a GOB, bytes are grouped into sectors of 16 bytes by 2 lines. The sectors are visited in a Z-shape. Between 1 and 32 GOBs, always a power of two, are stacked vertically to form a block. Blocks run left to right across the surface and then down, one block row at a time.

The stack height comes from a 3-bit log2 input. A value above 5 is illegal: it raises an error flag and forces the offset to zero. Alongside the address path, the block unpacks a 64-bit layout-modifier word. It reports whether the word names this layout with a legal height, this layout with an illegal height, the plain 16x16-byte tiled layout, or something else. When the height is legal, it also reports the log2 height carried in the word.

All results are registered with one cycle of latency. They load only on cycles where `valid_i` is high, and they hold otherwise.

Top module: `gob_addr_gen`

## Requirements
- R1: While reset is active, and after it until the first valid input, `valid_o`, `offset_o`, `herr_o`, `mkind_o` and `mlog2_o` are all zero.
- R2: `valid_o` equals the value `valid_i` had at the previous rising clock edge.
- R3: On a cycle with `valid_i` low, `offset_o`, `herr_o`, `mkind_o` and `mlog2_o` keep their values at the next edge, whatever the other inputs do.
- R4: The offset bits inside a GOB are formed as follows:
  - offset[3:0] = x[3:0]
  - offset[4] = y[0]
  - offset[5] = x[4]
  - offset[7:6] = y[2:1]
  - offset[8] = x[5]
  
  This walks the 16-byte-by-2-line sectors in a Z-shape over each 32-byte-wide half of the GOB.
- R5: With legal height h, the GOB's position in its block is (y/8) mod 2^h. It adds 512 times that position to the offset.
- R6: With legal height h, the block index is (y / (8*2^h)) * `wblk_i` + x/64. Each block spans 512*2^h bytes, so the offset is block_index*512*2^h + 512*gob + intra, where intra is the R4 value.
- R7: When `hlog2_i` is 6 or 7, `herr_o` is 1 and `offset_o` is 0. When it is 0 to 5, `herr_o` is 0.
- R8: The modifier word splits into three fields: vendor = bits [63:56], layout code = bits [55:32], parameter = bits [31:0]. With vendor equal to the VENDOR_ID parameter (default 8'h03), `mkind_o` is set as follows:
  - code 2 with parameter <= 5: `mkind_o` is 2 (block-linear).
  - code 2 with parameter > 5: `mkind_o` is 3 (illegal height).
  - code 1 with parameter 0: `mkind_o` is 1 (plain tile).
  - any other word: `mkind_o` is 0.
- R9: `mlog2_o` equals parameter[2:0] when `mkind_o` is 2, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input request is present |
| x_i | input | X_W (16) | Byte column on the surface |
| y_i | input | Y_W (14) | Line on the surface |
| wblk_i | input | WB_W (10) | Surface width in blocks |
| hlog2_i | input | 3 | log2 of GOBs per block |
| modw_i | input | 64 | Layout-modifier word to unpack |
| valid_o | output | 1 | Registered results are fresh |
| offset_o | output | OFF_W (32) | Byte offset in the block-linear layout |
| herr_o | output | 1 | `hlog2_i` was out of range |
| mkind_o | output | 2 | Modifier classification |
| mlog2_o | output | 3 | log2 height carried by the modifier |

## Verification
The hardest situations to reach are the block-row boundaries at the tall heights. With 32 GOBs per block, the first block row ends only at line 256. The row wrap, where the GOB position returns to 0 and the block index jumps by `wblk_i`, therefore needs lines far from the origin. The stimulus sweeps every height code 0 to 7 over lines 0..47 and over windows around lines 256 and 512. Each sweep pairs x steps that cross every sector, GOB half and block column for two surface widths. A wide-surface corner vector at the largest coordinates probes the top offset bits.

// File: rtl/gob_addr_pkg.sv
`timescale 1ns/1ps
package gob_addr_pkg;
    // GOB geometry: 64 bytes wide, 8 lines tall, 512 bytes in memory
    localparam int GOB_W_LOG2     = 6;
    localparam int GOB_H_LOG2     = 3;
    localparam int GOB_BYTES_LOG2 = GOB_W_LOG2 + GOB_H_LOG2;
    localparam int MAX_HLOG2      = 5;

    localparam logic [23:0] CODE_PLAIN  = 24'd1;
    localparam logic [23:0] CODE_BLKLIN = 24'd2;

    typedef enum logic [1:0] {
        MK_FOREIGN = 2'd0,
        MK_PLAIN   = 2'd1,
        MK_BLKLIN  = 2'd2,
        MK_BLKBAD  = 2'd3
    } mkind_e;
endpackage

// File: rtl/gob_swizzle.sv
`timescale 1ns/1ps
// Byte position inside one GOB: Z-walk of 16Bx2-line sectors per 32B half.
module gob_swizzle
    import gob_addr_pkg::*;
(
    input  logic [GOB_W_LOG2-1:0]     xlo_i,
    input  logic [GOB_H_LOG2-1:0]     ylo_i,
    output logic [GOB_BYTES_LOG2-1:0] intra_o
);
    always_comb begin
        intra_o = {xlo_i[5], ylo_i[2:1], xlo_i[4], ylo_i[0], xlo_i[3:0]};
    end
endmodule

// File: rtl/gob_block_place.sv
`timescale 1ns/1ps
// Block index and GOB-in-block arithmetic; returns the 512-byte-aligned base.
module gob_block_place
    import gob_addr_pkg::*;
#(
    parameter int X_W   = 16,
    parameter int Y_W   = 14,
    parameter int WB_W  = 10,
    parameter int OFF_W = 32
) (
    input  logic [X_W-1:0]   x_i,
    input  logic [Y_W-1:0]   y_i,
    input  logic [WB_W-1:0]  wblk_i,
    input  logic [2:0]       hlog2_i,
    output logic [OFF_W-1:0] base_o,
    output logic             err_o
);
    logic [2:0]           hsel;
    logic [MAX_HLOG2-1:0] gmask;
    logic [Y_W-1:0]       gob_rows;
    logic [Y_W-1:0]       brow;
    logic [OFF_W-1:0]     bidx;
    logic [OFF_W-1:0]     gsel;

    // Mask that keeps hsel low bits of the GOB row number
    for (genvar i = 0; i < MAX_HLOG2; i++) begin : g_mask
        assign gmask[i] = (hsel > 3'(i));
    end

    always_comb begin
        err_o    = (hlog2_i > 3'(MAX_HLOG2));
        hsel     = err_o ? 3'd0 : hlog2_i;
        gob_rows = y_i >> GOB_H_LOG2;
        brow     = y_i >> (GOB_H_LOG2 + int'(hsel));
        bidx     = OFF_W'(brow) * OFF_W'(wblk_i) + OFF_W'(x_i >> GOB_W_LOG2);
        gsel     = OFF_W'(gob_rows & Y_W'(gmask));
        base_o   = ((bidx << hsel) | gsel) << GOB_BYTES_LOG2;
    end
endmodule

// File: rtl/gob_mod_decode.sv
`timescale 1ns/1ps
// Classifies a 64-bit layout-modifier word and extracts its height parameter.
module gob_mod_decode
    import gob_addr_pkg::*;
#(
    parameter logic [7:0] VENDOR_ID = 8'h03
) (
    input  logic [63:0] modw_i,
    output mkind_e      kind_o,
    output logic [2:0]  log2_o
);
    logic [7:0]  vend;
    logic [23:0] code;
    logic [31:0] parm;

    always_comb begin
        vend   = modw_i[63:56];
        code   = modw_i[55:32];
        parm   = modw_i[31:0];
        kind_o = MK_FOREIGN;
        log2_o = 3'd0;
        if (vend == VENDOR_ID) begin
            if (code == CODE_BLKLIN) begin
                if (parm <= 32'(MAX_HLOG2)) begin
                    kind_o = MK_BLKLIN;
                    log2_o = parm[2:0];
                end else begin
                    kind_o = MK_BLKBAD;
                end
            end else if (code == CODE_PLAIN && parm == 32'd0) begin
                kind_o = MK_PLAIN;
            end
        end
    end
endmodule

// File: rtl/gob_addr_gen.sv
`timescale 1ns/1ps
module gob_addr_gen
    import gob_addr_pkg::*;
#(
    parameter int         X_W       = 16,
    parameter int         Y_W       = 14,
    parameter int         WB_W      = 10,
    parameter int         OFF_W     = 32,
    parameter logic [7:0] VENDOR_ID = 8'h03
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [X_W-1:0]   x_i,
    input  logic [Y_W-1:0]   y_i,
    input  logic [WB_W-1:0]  wblk_i,
    input  logic [2:0]       hlog2_i,
    input  logic [63:0]      modw_i,
    output logic             valid_o,
    output logic [OFF_W-1:0] offset_o,
    output logic             herr_o,
    output logic [1:0]       mkind_o,
    output logic [2:0]       mlog2_o
);
    typedef struct packed {
        logic             vld;
        logic [OFF_W-1:0] off;
        logic             err;
        mkind_e           mkind;
        logic [2:0]       mlog2;
    } state_t;

    state_t st_d, st_q;

    logic [GOB_BYTES_LOG2-1:0] intra;
    logic [OFF_W-1:0]          base;
    logic                      herr;
    mkind_e                    mkind;
    logic [2:0]                mlog2;

    gob_swizzle swz_i (
        .xlo_i   (x_i[GOB_W_LOG2-1:0]),
        .ylo_i   (y_i[GOB_H_LOG2-1:0]),
        .intra_o (intra)
    );

    gob_block_place #(
        .X_W   (X_W),
        .Y_W   (Y_W),
        .WB_W  (WB_W),
        .OFF_W (OFF_W)
    ) place_i (
        .x_i     (x_i),
        .y_i     (y_i),
        .wblk_i  (wblk_i),
        .hlog2_i (hlog2_i),
        .base_o  (base),
        .err_o   (herr)
    );

    gob_mod_decode #(
        .VENDOR_ID (VENDOR_ID)
    ) mdec_i (
        .modw_i (modw_i),
        .kind_o (mkind),
        .log2_o (mlog2)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.err   = herr;
            st_d.off   = herr ? '0 : (base | OFF_W'(intra));
            st_d.mkind = mkind;
            st_d.mlog2 = mlog2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{vld: 1'b0, off: '0, err: 1'b0, mkind: MK_FOREIGN, mlog2: 3'd0};
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.vld;
    assign offset_o = st_q.off;
    assign herr_o   = st_q.err;
    assign mkind_o  = st_q.mkind;
    assign mlog2_o  = st_q.mlog2;
endmodule

// File: rtl/gob_addr_chk.sv
`timescale 1ns/1ps
module gob_addr_chk #(
    parameter int OFF_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             valid_i,
    input logic [3:0]       xlo_i,
    input logic [2:0]       hlog2_i,
    input logic             valid_o,
    input logic [OFF_W-1:0] offset_o,
    input logic             herr_o,
    input logic [1:0]       mkind_o,
    input logic [2:0]       mlog2_o
);
    // R2
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);
    // R2
    idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);
    // R3
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(offset_o) && $stable(herr_o) && $stable(mkind_o) && $stable(mlog2_o)));
    // R7
    err_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && hlog2_i > 3'd5) |=> herr_o);
    // R7
    err_zero_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        herr_o |-> (offset_o == '0));
    // R4
    low_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && hlog2_i <= 3'd5) |=> (offset_o[3:0] == $past(xlo_i)));
    // R9
    mlog2_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mkind_o != 2'd2) |-> (mlog2_o == 3'd0));
endmodule

bind gob_addr_gen gob_addr_chk #(.OFF_W(OFF_W)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .xlo_i    (x_i[3:0]),
    .hlog2_i  (hlog2_i),
    .valid_o  (valid_o),
    .offset_o (offset_o),
    .herr_o   (herr_o),
    .mkind_o  (mkind_o),
    .mlog2_o  (mlog2_o)
);

// File: tb/gob_addr_gen_tb_top.sv
`timescale 1ns/1ps
module gob_addr_gen_tb_top;
    localparam int X_W   = 16;
    localparam int Y_W   = 14;
    localparam int WB_W  = 10;
    localparam int OFF_W = 32;

    logic             clk_i = 1'b0;
    logic             rst_ni;
    logic             valid_i;
    logic [X_W-1:0]   x_i;
    logic [Y_W-1:0]   y_i;
    logic [WB_W-1:0]  wblk_i;
    logic [2:0]       hlog2_i;
    logic [63:0]      modw_i;
    logic             valid_o;
    logic [OFF_W-1:0] offset_o;
    logic             herr_o;
    logic [1:0]       mkind_o;
    logic [2:0]       mlog2_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk_i = ~clk_i;

    gob_addr_gen dut_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (valid_i),
        .x_i      (x_i),
        .y_i      (y_i),
        .wblk_i   (wblk_i),
        .hlog2_i  (hlog2_i),
        .modw_i   (modw_i),
        .valid_o  (valid_o),
        .offset_o (offset_o),
        .herr_o   (herr_o),
        .mkind_o  (mkind_o),
        .mlog2_o  (mlog2_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint model_off(input longint x, input longint y,
                                         input longint w, input int h);
        longint intra, gob, brow, bidx;
        if (h > 5) return 0;
        intra = (x % 16) + (y % 2) * 16 + ((x / 16) % 2) * 32
              + ((y / 2) % 4) * 64 + ((x / 32) % 2) * 256;
        gob   = (y / 8) % (longint'(1) << h);
        brow  = y / (longint'(8) << h);
        bidx  = brow * w + x / 64;
        return (bidx * (longint'(512) << h) + gob * 512 + intra) % (longint'(1) << OFF_W);
    endfunction

    // Drive one request at a falling edge, sample results one full cycle later
    task automatic apply(input int x, input int y, input int w, input int h,
                         input logic [63:0] m, input int ekind, input int elog2);
        valid_i = 1'b1;
        x_i     = X_W'(x);
        y_i     = Y_W'(y);
        wblk_i  = WB_W'(w);
        hlog2_i = 3'(h);
        modw_i  = m;
        @(posedge clk_i);
        @(negedge clk_i);
        valid_i = 1'b0;
        check("R2 valid_o", longint'(valid_o), 1);
        check("R7 herr_o", longint'(herr_o), (h > 5) ? 1 : 0);
        check("R4 R5 R6 offset_o", longint'(offset_o), model_off(x, y, w, h));
        check("R8 mkind_o", longint'(mkind_o), ekind);
        check("R9 mlog2_o", longint'(mlog2_o), elog2);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_ni  = 1'b0;
        valid_i = 1'b0;
        x_i     = '0;
        y_i     = '0;
        wblk_i  = '0;
        hlog2_i = '0;
        modw_i  = '0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        // R1 reset state
        check("R1 valid_o", longint'(valid_o), 0);
        check("R1 offset_o", longint'(offset_o), 0);
        check("R1 herr_o", longint'(herr_o), 0);
        check("R1 mkind_o", longint'(mkind_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 valid_o idle", longint'(valid_o), 0);
        check("R1 mlog2_o", longint'(mlog2_o), 0);

        // R4 fixed point: x=0x2B, y=5 -> x[3:0]=B, y0=1, x4=0, y[2:1]=2, x5=1
        apply(43, 5, 1, 0, 64'd0, 0, 0);
        check("R4 intra", longint'(offset_o), 64'h19B);

        // R5 R6 R7 sweep of all height codes
        for (int h = 0; h < 8; h++) begin
            for (int wi = 0; wi < 2; wi++) begin
                int w    = (wi == 0) ? 1 : 3;
                int step = (wi == 0) ? 3 : 7;
                for (int yi = 0; yi < 80; yi++) begin
                    int y = (yi < 48) ? yi : ((yi < 64) ? 248 + (yi - 48) : 504 + (yi - 64));
                    for (int x = 0; x < w * 64; x += step) begin
                        apply(x, y, w, h, 64'd0, 0, 0);
                    end
                end
            end
        end

        // R6 wide-surface corner
        apply(63999, 16383, 1000, 5, 64'd0, 0, 0);
        apply(63999, 16383, 1000, 0, 64'd0, 0, 0);

        // R3 hold: valid low with changed inputs leaves results unchanged
        apply(100, 77, 2, 2, {8'h03, 24'd2, 32'd4}, 2, 4);
        valid_i = 1'b0;
        x_i = 16'h1234; y_i = 14'h0555; hlog2_i = 3'd7; modw_i = {8'h03, 24'd1, 32'd0};
        @(posedge clk_i);
        @(negedge clk_i);
        check("R2 valid_o low", longint'(valid_o), 0);
        check("R3 offset_o held", longint'(offset_o), model_off(100, 77, 2, 2));
        check("R3 herr_o held", longint'(herr_o), 0);
        check("R3 mkind_o held", longint'(mkind_o), 2);
        check("R3 mlog2_o held", longint'(mlog2_o), 4);

        // R8 R9 modifier classification
        apply(0, 0, 1, 0, {8'h03, 24'd2, 32'd3},     2, 3);
        apply(0, 0, 1, 0, {8'h03, 24'd2, 32'd0},     2, 0);
        apply(0, 0, 1, 0, {8'h03, 24'd2, 32'd5},     2, 5);
        apply(0, 0, 1, 0, {8'h03, 24'd2, 32'd6},     3, 0);
        apply(0, 0, 1, 0, {8'h03, 24'd2, 32'h102},   3, 0);
        apply(0, 0, 1, 0, {8'h03, 24'd1, 32'd0},     1, 0);
        apply(0, 0, 1, 0, {8'h03, 24'd1, 32'd1},     0, 0);
        apply(0, 0, 1, 0, {8'h04, 24'd2, 32'd1},     0, 0);
        apply(0, 0, 1, 0, {8'h03, 24'h10002, 32'd1}, 0, 0);
        apply(0, 0, 1, 0, {8'h03, 24'd3, 32'd1},     0, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule